// File: doc/BRIEF.md
# Triggered Detector Readout Sequencer

This block runs one readout of a detector front end each time it is triggered. The trigger is a command written by the host or a rising edge on an external input, as the configuration selects. When triggered, the block goes busy and drives a sample pulse of programmable length. After a programmable delay it raises start-conversion. Then it waits, within a bounded window, for the front end to open a serial frame. The frame is delimited by a low sync line. Bits are clocked by strobe rising edges, most significant bit first, and each complete 12-bit word is written into the next location of a 60-entry local buffer. The host reads that buffer through a plain address/data read port.

All timing comes from a 5 MHz clock divided by five into a 1 µs base. A configuration word sets the two delays and three mode bits: real or test, internal or external trigger, and hold-until-released or continuous re-arming. A command word issues the software trigger, releases a held result, or forces a soft reset. In test mode the serial lines play no part, and the buffer is filled with a fixed word so the readout path can be checked on its own.

Top module: `acq_sequencer`

## Requirements
- R1: After rst_n low, and one cycle after a command write of 0x4053 in any state, busy, done, sample_pulse, start_conv and xfer_timeout are all 0. The configuration is kept.
- R2: Configuration bit 2 selects the trigger source. With bit 2 = 0, a command write of 0x7101 starts a cycle and external rising edges are ignored. With bit 2 = 1, a rising edge on ext_trig starts a cycle and 0x7101 is ignored. The clock edge that samples the trigger sets busy.
- R3: sample_pulse rises on the trigger edge and stays high for exactly 5×T1 cycles, where T1 is configuration bits [15:8]. When T1 = 0 there is no pulse.
- R4: start_conv rises 5×T2 cycles after sample_pulse falls, or 5×T2 cycles after the trigger when T1 = 0. T2 is configuration bits [23:16], and T2 = 0 gives no gap.
- R5: While start_conv is high, a low sync is accepted only once at least one full microsecond (5 cycles) has elapsed; an earlier low keeps start_conv high until then. If sync is not accepted by 4 µs (20 cycles), start_conv falls, done and xfer_timeout rise, and no data is taken.
- R6: Once sync has been accepted, each strobe rising edge with sync low shifts in one data bit, most significant bit first. Every 12th bit completes a word, which is stored at the next buffer address starting at 0.
- R7: At most 60 words are stored per cycle. Further words in the same frame leave the buffer unchanged.
- R8: done rises one cycle after sync returns high, with xfer_timeout 0. done is 0 before that.
- R9: With configuration bit 3 = 0 (busy mode), busy and done stay high after the frame until a command write of 0x7102. Triggers in that interval are ignored.
- R10: With configuration bit 3 = 1 (continuous mode), busy falls when done rises. The next trigger is accepted and clears done.
- R11: With configuration bit 1 = 0 (test mode), start_conv is never raised and the serial lines are ignored. After the delays, all 60 locations are written with 0xA5C, then done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration: [1] real, [2] external trigger, [3] continuous, [15:8] T1, [23:16] T2 |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command: 0x7101 trigger, 0x7102 release, 0x4053 soft reset |
| ext_trig | input | 1 | External trigger, rising edge active |
| fe_sync | input | 1 | Frame sync from front end, low during a frame |
| fe_stb | input | 1 | Bit strobe from front end |
| fe_data | input | 1 | Serial data from front end |
| rd_addr | input | 6 | Buffer read address |
| rd_data | output | 12 | Buffer word at rd_addr |
| busy | output | 1 | Acquisition cycle in progress or held |
| done | output | 1 | Cycle finished |
| sample_pulse | output | 1 | Sample pulse to front end |
| start_conv | output | 1 | Start-conversion to front end |
| xfer_timeout | output | 1 | Frame did not start within the window |

## Verification
The bench builds the block with its default parameters: a divider of 5, 60 words of 12 bits, and a window of 1 to 4 µs. This keeps every phase short enough to count cycle by cycle. Programmed delays of 0 to 3 µs cover the skipped phases, exact pulse widths, the early-sync hold-off and the timeout. The 60-word depth lets one frame overrun the buffer by two words and shows that the last location is not overwritten.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_DELAY,
        ST_WINDOW,
        ST_RECV,
        ST_FILL,
        ST_HOLD
    } seq_state_e;

    // Command word codes
    localparam logic [15:0] CMD_SOFT_RESET = 16'h4053;
    localparam logic [15:0] CMD_TRIGGER    = 16'h7101;
    localparam logic [15:0] CMD_RELEASE    = 16'h7102;

    // Configuration word layout
    localparam int CFG_W    = 24;
    localparam int DLY_W    = 8;
    localparam int REAL_BIT = 1;
    localparam int EXT_BIT  = 2;
    localparam int CONT_BIT = 3;
    localparam int T1_LSB   = 8;
    localparam int T2_LSB   = 16;

endpackage

// File: rtl/acq_us_timer.sv
module acq_us_timer #(
    parameter int DIV   = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic             tick_o,
    output logic [CNT_W-1:0] us_o
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
    localparam logic [CNT_W-1:0] US_MAX   = '1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [CNT_W-1:0] us_d, us_q;

    assign tick_o = (div_q == DIV_LAST);
    assign us_o   = us_q;

    always_comb begin
        div_d = tick_o ? '0 : div_q + DIV_W'(1);
        us_d  = us_q;
        if (tick_o && us_q != US_MAX) begin
            us_d = us_q + CNT_W'(1);
        end
        if (clr) begin
            div_d = '0;
            us_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            us_q  <= '0;
        end else begin
            div_q <= div_d;
            us_q  <= us_d;
        end
    end
endmodule

// File: rtl/acq_frame_rx.sv
module acq_frame_rx #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sync,
    input  logic              stb,
    input  logic              data,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic              stb_d, stb_q;
    logic [WORD_W-2:0] sh_d, sh_q;
    logic [BIT_W-1:0]  cnt_d, cnt_q;
    logic              vld_d, vld_q;
    logic [WORD_W-1:0] word_d, word_q;

    assign word_vld_o = vld_q;
    assign word_o     = word_q;

    always_comb begin
        stb_d  = stb;
        sh_d   = sh_q;
        cnt_d  = cnt_q;
        vld_d  = 1'b0;
        word_d = word_q;
        if (!en) begin
            cnt_d = '0;
        end else if (!sync && stb && !stb_q) begin
            sh_d = {sh_q[WORD_W-3:0], data};
            if (cnt_q == BIT_LAST) begin
                cnt_d  = '0;
                vld_d  = 1'b1;
                word_d = {sh_q, data};
            end else begin
                cnt_d = cnt_q + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            sh_q   <= '0;
            cnt_q  <= '0;
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            stb_q  <= stb_d;
            sh_q   <= sh_d;
            cnt_q  <= cnt_d;
            vld_q  <= vld_d;
            word_q <= word_d;
        end
    end
endmodule

// File: rtl/acq_buffer.sv
module acq_buffer #(
    parameter int W     = 12,
    parameter int DEPTH = 60,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < DEPTH_V)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = ({1'b0, raddr} < DEPTH_V) ? mem[raddr] : '0;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int              WORD_W     = 12,
    parameter int              NUM_WORDS  = 60,
    parameter int              TICK_DIV   = 5,
    parameter int              WIN_MIN_US = 1,
    parameter int              WIN_MAX_US = 4,
    parameter logic [WORD_W-1:0] TEST_WORD = 12'hA5C,
    parameter int              ADDR_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [23:0]       cfg_wdata,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_wdata,
    input  logic              ext_trig,
    input  logic              fe_sync,
    input  logic              fe_stb,
    input  logic              fe_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              sample_pulse,
    output logic              start_conv,
    output logic              xfer_timeout
);
    localparam int PTR_W = $clog2(NUM_WORDS + 1);
    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(NUM_WORDS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_WORDS - 1);
    localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] WIN_MIN_V  = DLY_W'(WIN_MIN_US);
    localparam logic [DLY_W-1:0] WIN_LAST_V = DLY_W'(WIN_MAX_US - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [DLY_W-1:0] t1;
        logic [DLY_W-1:0] t2;
        logic             real_m;
        logic             ext_m;
        logic             cont_m;
        logic             done;
        logic             timeout;
        logic             ext_q;
        logic [PTR_W-1:0] ptr;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        state:   ST_IDLE,
        t1:      '0,
        t2:      '0,
        real_m:  1'b0,
        ext_m:   1'b0,
        cont_m:  1'b0,
        done:    1'b0,
        timeout: 1'b0,
        ext_q:   1'b0,
        ptr:     '0
    };

    seq_regs_t r_d, r_q;

    logic              tmr_clr;
    logic              tick;
    logic [DLY_W-1:0]  us_cnt;
    logic              rx_vld;
    logic [WORD_W-1:0] rx_word;
    logic              buf_we;
    logic [WORD_W-1:0] buf_wdata;
    logic              cfg_unused;

    assign cfg_unused = ^{cfg_wdata[7:4], cfg_wdata[0]};

    acq_us_timer #(
        .DIV   (TICK_DIV),
        .CNT_W (DLY_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick_o (tick),
        .us_o   (us_cnt)
    );

    acq_frame_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (r_q.state == ST_RECV),
        .sync       (fe_sync),
        .stb        (fe_stb),
        .data       (fe_data),
        .word_vld_o (rx_vld),
        .word_o     (rx_word)
    );

    acq_buffer #(
        .W     (WORD_W),
        .DEPTH (NUM_WORDS),
        .AW    (ADDR_W)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (r_q.ptr[ADDR_W-1:0]),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        logic       trig;
        logic       cmd_trig;
        logic       cmd_rel;
        logic       cmd_rst;
        seq_state_e after_delay;
        seq_state_e after_sample;
        seq_state_e after_trig;
        seq_state_e end_state;

        r_d       = r_q;
        buf_we    = 1'b0;
        buf_wdata = rx_word;

        cmd_trig = cmd_we && (cmd_wdata == CMD_TRIGGER);
        cmd_rel  = cmd_we && (cmd_wdata == CMD_RELEASE);
        cmd_rst  = cmd_we && (cmd_wdata == CMD_SOFT_RESET);

        r_d.ext_q = ext_trig;
        trig = r_q.ext_m ? (ext_trig && !r_q.ext_q) : cmd_trig;

        after_delay  = r_q.real_m ? ST_WINDOW : ST_FILL;
        after_sample = (r_q.t2 != '0) ? ST_DELAY : after_delay;
        after_trig   = (r_q.t1 != '0) ? ST_SAMPLE : after_sample;
        end_state    = r_q.cont_m ? ST_IDLE : ST_HOLD;

        if (cfg_we) begin
            r_d.t1     = cfg_wdata[T1_LSB +: DLY_W];
            r_d.t2     = cfg_wdata[T2_LSB +: DLY_W];
            r_d.real_m = cfg_wdata[REAL_BIT];
            r_d.ext_m  = cfg_wdata[EXT_BIT];
            r_d.cont_m = cfg_wdata[CONT_BIT];
        end

        // Received words go to the next free location until the buffer is full
        if (rx_vld && (r_q.ptr < PTR_FULL)) begin
            buf_we  = 1'b1;
            r_d.ptr = r_q.ptr + PTR_W'(1);
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_rel) begin
                    r_d.done    = 1'b0;
                    r_d.timeout = 1'b0;
                end
                if (trig) begin
                    r_d.done    = 1'b0;
                    r_d.timeout = 1'b0;
                    r_d.ptr     = '0;
                    r_d.state   = after_trig;
                end
            end
            ST_SAMPLE: begin
                if (tick && us_cnt == r_q.t1 - DLY_ONE) begin
                    r_d.state = after_sample;
                end
            end
            ST_DELAY: begin
                if (tick && us_cnt == r_q.t2 - DLY_ONE) begin
                    r_d.state = after_delay;
                end
            end
            ST_WINDOW: begin
                if (!fe_sync && us_cnt >= WIN_MIN_V) begin
                    r_d.state = ST_RECV;
                end else if (tick && us_cnt == WIN_LAST_V) begin
                    r_d.timeout = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.state   = end_state;
                end
            end
            ST_RECV: begin
                if (fe_sync) begin
                    r_d.done  = 1'b1;
                    r_d.state = end_state;
                end
            end
            ST_FILL: begin
                buf_we    = 1'b1;
                buf_wdata = TEST_WORD;
                r_d.ptr   = r_q.ptr + PTR_W'(1);
                if (r_q.ptr == PTR_LAST) begin
                    r_d.done  = 1'b1;
                    r_d.state = end_state;
                end
            end
            ST_HOLD: begin
                if (cmd_rel) begin
                    r_d.done    = 1'b0;
                    r_d.timeout = 1'b0;
                    r_d.state   = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (cmd_rst) begin
            r_d.state   = ST_IDLE;
            r_d.done    = 1'b0;
            r_d.timeout = 1'b0;
            r_d.ptr     = '0;
            buf_we      = 1'b0;
        end

        tmr_clr = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign done         = r_q.done;
    assign sample_pulse = (r_q.state == ST_SAMPLE);
    assign start_conv   = (r_q.state == ST_WINDOW);
    assign xfer_timeout = r_q.timeout;
endmodule

// File: rtl/acq_sequencer_checker.sv
module acq_sequencer_checker
    import acq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [15:0] cmd_wdata,
    input logic        busy,
    input logic        done,
    input logic        sample_pulse,
    input logic        start_conv,
    input logic        xfer_timeout
);
    a_r1_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata == CMD_SOFT_RESET) |=>
            (!busy && !done && !sample_pulse && !start_conv && !xfer_timeout));

    a_r2_new_cycle_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    a_r3_sample_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> (busy && !done));

    a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pulse && start_conv));

    a_r5_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_timeout |-> done);

    a_r9_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && !cmd_we) |=> (busy && done));
endmodule

bind acq_sequencer acq_sequencer_checker u_acq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_wdata    (cmd_wdata),
    .busy         (busy),
    .done         (done),
    .sample_pulse (sample_pulse),
    .start_conv   (start_conv),
    .xfer_timeout (xfer_timeout)
);

// File: tb/acq_sequencer_bench.sv
`timescale 1ns/1ps
module acq_sequencer_bench;
    localparam int CLK_PERIOD = 200;
    localparam logic [15:0] C_TRIG  = 16'h7101;
    localparam logic [15:0] C_REL   = 16'h7102;
    localparam logic [15:0] C_RESET = 16'h4053;
    localparam logic [11:0] FILL_WORD = 12'hA5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        ext_trig = 1'b0;
    logic        fe_sync = 1'b1;
    logic        fe_stb = 1'b0;
    logic        fe_data = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        busy, done, sample_pulse, start_conv, xfer_timeout;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sequencer u_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .ext_trig(ext_trig),
        .fe_sync(fe_sync), .fe_stb(fe_stb), .fe_data(fe_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .sample_pulse(sample_pulse), .start_conv(start_conv),
        .xfer_timeout(xfer_timeout)
    );

    function automatic logic [11:0] pat(int seed, int i);
        return 12'((i * 293 + seed * 77 + 21) & 12'hFFF);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(int t2, int t1, bit cont, bit ext, bit realm);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {8'(t2), 8'(t1), 4'b0, cont, ext, realm, 1'b0};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cmd(logic [15:0] code);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = code;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic count_while(input logic which, output int n);
        n = 0;
        while ((which ? start_conv : sample_pulse) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_conv(output int n);
        n = 0;
        while (!start_conv && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(int nwords, int seed);
        for (int i = 0; i < nwords; i++) begin
            logic [11:0] w;
            w = pat(seed, i);
            for (int b = 11; b >= 0; b--) begin
                fe_data = w[b];
                fe_stb = 1'b0;
                @(negedge clk);
                fe_stb = 1'b1;
                @(negedge clk);
            end
        end
        fe_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_buffer(string req, int seed, bit fixed);
        int bad;
        bad = 0;
        for (int a = 0; a < 60; a++) begin
            logic [11:0] e;
            @(negedge clk);
            rd_addr = 6'(a);
            #1;
            e = fixed ? FILL_WORD : pat(seed, a);
            if (rd_data !== e) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, a, rd_data, e);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic t_reset();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset sample", sample_pulse, 0);
        chk("R1 reset start_conv", start_conv, 0);
        chk("R1 reset timeout", xfer_timeout, 0);
    endtask

    task automatic t_real_busy_mode();
        int n;
        set_cfg(2, 3, 1'b0, 1'b0, 1'b1);
        cmd(C_TRIG);
        chk("R2 busy on sw trigger", busy, 1);
        count_while(1'b0, n);
        chk("R3 sample width 5*T1", n, 15);
        wait_conv(n);
        chk("R4 gap 5*T2", n, 10);
        fe_sync = 1'b0;
        count_while(1'b1, n);
        chk("R5 early sync held off to 1us", n, 6);
        send_frame(60, 1);
        chk("R8 done low before sync high", done, 0);
        fe_sync = 1'b1;
        @(negedge clk);
        chk("R8 done on sync high", done, 1);
        chk("R8 no timeout", xfer_timeout, 0);
        chk("R9 busy held", busy, 1);
        check_buffer("R6 captured words", 1, 1'b0);
        cmd(C_TRIG);
        chk("R9 trigger ignored sample", sample_pulse, 0);
        chk("R9 trigger ignored done", done, 1);
        repeat (3) @(negedge clk);
        chk("R9 still held", busy, 1);
        cmd(C_REL);
        chk("R9 release busy", busy, 0);
        chk("R9 release done", done, 0);
    endtask

    task automatic t_timeout();
        int n;
        set_cfg(0, 0, 1'b0, 1'b0, 1'b1);
        cmd(C_TRIG);
        chk("R3 T1=0 no sample", sample_pulse, 0);
        chk("R4 T2=0 immediate start_conv", start_conv, 1);
        count_while(1'b1, n);
        chk("R5 window length", n, 20);
        chk("R5 timeout flag", xfer_timeout, 1);
        chk("R5 timeout done", done, 1);
        cmd(C_REL);
        chk("R5 timeout cleared", xfer_timeout, 0);
    endtask

    task automatic t_continuous_overflow();
        int n;
        set_cfg(1, 1, 1'b1, 1'b0, 1'b1);
        cmd(C_TRIG);
        wait_conv(n);
        fe_sync = 1'b0;
        count_while(1'b1, n);
        send_frame(62, 2);
        fe_sync = 1'b1;
        @(negedge clk);
        chk("R10 done in continuous", done, 1);
        chk("R10 busy drops", busy, 0);
        check_buffer("R7 only 60 words kept", 2, 1'b0);
        cmd(C_TRIG);
        chk("R10 re-armed busy", busy, 1);
        chk("R10 re-armed clears done", done, 0);
        cmd(C_RESET);
    endtask

    task automatic t_test_mode();
        int n;
        bit seen_conv;
        set_cfg(1, 1, 1'b0, 1'b0, 1'b0);
        cmd(C_TRIG);
        seen_conv = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            if (start_conv) seen_conv = 1'b1;
            fe_sync = 1'b0;
            fe_stb = ~fe_stb;
            fe_data = ~fe_data;
            n++;
            @(negedge clk);
        end
        fe_sync = 1'b1;
        fe_stb = 1'b0;
        chk("R11 no start_conv in test mode", seen_conv, 0);
        chk("R11 done after fill", done, 1);
        check_buffer("R11 fill word", 0, 1'b1);
        cmd(C_REL);
    endtask

    task automatic t_trigger_source();
        set_cfg(0, 2, 1'b0, 1'b1, 1'b1);
        cmd(C_TRIG);
        chk("R2 sw trigger ignored in ext", busy, 0);
        ext_pulse();
        chk("R2 ext trigger busy", busy, 1);
        chk("R2 ext trigger sample", sample_pulse, 1);
        cmd(C_RESET);
        chk("R1 soft reset busy", busy, 0);
        chk("R1 soft reset sample", sample_pulse, 0);
        set_cfg(0, 2, 1'b0, 1'b0, 1'b1);
        ext_pulse();
        chk("R2 ext ignored in sw", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_real_busy_mode();
        t_timeout();
        t_continuous_overflow();
        t_test_mode();
        t_trigger_source();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule